// File: doc/BRIEF.md
# Coded-Ratio Tick Prescaler

This block turns a 4-bit rate code into a periodic one-cycle tick on the source clock. The tick serves only as a clock enable for a downstream counter; no new clock domain is created. The ratios come from a fixed, sparse table that is not a power-of-two series. The low band divides by 120, 180, 240, 360 or 480. The high band divides by 12000, 24000, 36000, 48000 or 72000. Several codes in between are reserved.

A run input gates the prescaler. While the run input is low, the internal count is held at zero and no ticks appear. Software is expected to change the code only while the run input is low, so that no partial interval is produced. If the code does change while running, the interval restarts cleanly. A build-time parameter decides whether the all-ones code is a divide-by-one escape, which ticks on every source cycle, or a reserved code.

Top module: `ratio_tick_gen`

## Requirements
- R1: After reset, `tickOut` is low, and it stays low until `runEn` is sampled high with a valid code.
- R2: Codes 0, 1, 2, 3 and 4 give ratios N of 120, 180, 240, 360 and 480. Counting the first clock edge that samples `runEn` high as edge 1, `tickOut` is high in the cycle after edge N, after edge 2N, and so on.
- R3: Codes 8, 9, 10, 11 and 12 give ratios of 12000, 24000, 36000, 48000 and 72000, with the same timing as in R2.
- R4: Codes 5, 6, 7, 13 and 14 are reserved. While one of them is applied, `tickOut` stays low.
- R5: With `ESCAPE_EN`=1, code 15 divides by one. `tickOut` is high in the cycle after every edge that samples `runEn` high.
- R6: With `ESCAPE_EN`=0, code 15 is reserved and `tickOut` stays low.
- R7: For every ratio above one, `tickOut` is high for exactly one cycle per interval.
- R8: An edge that samples `runEn` low drives `tickOut` low and clears the count. After `runEn` is raised again, the first tick comes a full N edges later.
- R9: If `rateSel` changes while `runEn` is high, the interval restarts. The first edge that samples the new code counts as edge 1, and the first tick follows N_new edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 4 | Rate code selecting the divide ratio |
| runEn | input | 1 | Gate; low holds the count at zero and suppresses ticks |
| tickOut | output | 1 | One-cycle clock-enable tick |

## Verification
The bench measures the exact edge of every tick for each low-band ratio and for the smallest and largest high-band ratios. A counter that compares against N instead of N-1 would show up as a tick one cycle late. The bench runs each reserved code, and code 15 on a build without the escape, to catch a decode that falls through to some nonzero ratio. It gates off right at a tick and restarts after a partial interval, so a count that survives gating, or a tick that lingers, is reported. It also changes the code mid-run, which exposes a design that loses a cycle or keeps the stale count.

// File: rtl/ratio_tick_pkg.sv
package ratio_tick_pkg;
  localparam int CODE_W    = 4;
  localparam int MAX_RATIO = 72000;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;      // count this edge
    logic restart;  // treat the current count as zero
  } strobe_t;

  // terminal count (ratio - 1) of a code; 0 for reserved codes
  function automatic cnt_t codeLimit(input code_t code);
    case (code)
      4'd0:    codeLimit = cnt_t'(119);
      4'd1:    codeLimit = cnt_t'(179);
      4'd2:    codeLimit = cnt_t'(239);
      4'd3:    codeLimit = cnt_t'(359);
      4'd4:    codeLimit = cnt_t'(479);
      4'd8:    codeLimit = cnt_t'(11999);
      4'd9:    codeLimit = cnt_t'(23999);
      4'd10:   codeLimit = cnt_t'(35999);
      4'd11:   codeLimit = cnt_t'(47999);
      4'd12:   codeLimit = cnt_t'(71999);
      default: codeLimit = '0;
    endcase
  endfunction

  function automatic logic codeValid(input code_t code, input logic escOk);
    case (code)
      4'd5, 4'd6, 4'd7, 4'd13, 4'd14: codeValid = 1'b0;
      4'd15:                          codeValid = escOk;
      default:                        codeValid = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ratio_tick_ctrl.sv
module ratio_tick_ctrl
  import ratio_tick_pkg::*;
#(
  parameter bit ESCAPE_EN = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  code_t   rateSel,
  input  logic    runEn,
  output strobe_t strobes,
  output cnt_t    limit
);
  code_t prevSel;
  logic  selOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSel <= '0;
    else       prevSel <= rateSel;
  end

  always_comb begin
    selOk           = codeValid(rateSel, ESCAPE_EN);
    limit           = codeLimit(rateSel);
    strobes.run     = runEn && selOk;
    strobes.restart = (rateSel != prevSel);
  end
endmodule

// File: rtl/ratio_tick_count.sv
module ratio_tick_count
  import ratio_tick_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  cnt_t    limit,
  output logic    tickOut
);
  cnt_t cnt;
  cnt_t base;

  always_comb base = strobes.restart ? '0 : cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      tickOut <= 1'b0;
    end else if (!strobes.run) begin
      cnt     <= '0;
      tickOut <= 1'b0;
    end else if (base == limit) begin
      cnt     <= '0;
      tickOut <= 1'b1;
    end else begin
      cnt     <= base + 1'b1;
      tickOut <= 1'b0;
    end
  end
endmodule

// File: rtl/ratio_tick_gen.sv
module ratio_tick_gen
  import ratio_tick_pkg::*;
#(
  parameter bit ESCAPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] rateSel,
  input  logic              runEn,
  output logic              tickOut
);
  strobe_t strobes;
  cnt_t    limit;

  ratio_tick_ctrl #(.ESCAPE_EN(ESCAPE_EN)) ctrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .runEn(runEn),
    .strobes(strobes), .limit(limit)
  );

  ratio_tick_count dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .limit(limit), .tickOut(tickOut)
  );
endmodule

// File: rtl/ratio_tick_gen_chk.sv
module ratio_tick_gen_chk #(
  parameter bit ESCAPE_EN = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] rateSel,
  input logic       runEn,
  input logic       tickOut
);
  logic isReserved;
  logic isEscape;

  always_comb begin
    isEscape   = ESCAPE_EN && (rateSel == 4'hF);
    isReserved = (rateSel == 4'd5) || (rateSel == 4'd6) || (rateSel == 4'd7) ||
                 (rateSel == 4'd13) || (rateSel == 4'd14) ||
                 (!ESCAPE_EN && rateSel == 4'hF);
  end

  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !tickOut);

  // also covers R6 when the escape is not built in
  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    isReserved |=> !tickOut);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && !isEscape) |=> !tickOut);

  assert_escape_every_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && isEscape) |=> tickOut);
endmodule

bind ratio_tick_gen ratio_tick_gen_chk #(.ESCAPE_EN(ESCAPE_EN)) chk (
  .clk(clk), .rstN(rstN), .rateSel(rateSel), .runEn(runEn), .tickOut(tickOut)
);

// File: tb/ratio_tick_gen_test.sv
module ratio_tick_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic       runEn = 1'b0;
  logic       tickOut;
  logic       tickNoEsc;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int seen = 0;
  int escTicks = 0;
  bit prevTick = 1'b0;
  bit finished = 1'b0;
  string curTag = "R1";
  int expQ[$];

  always #5 clk = ~clk;

  ratio_tick_gen uut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .runEn(runEn), .tickOut(tickOut)
  );

  ratio_tick_gen #(.ESCAPE_EN(1'b0)) uutNoEsc (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .runEn(runEn), .tickOut(tickNoEsc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refRatio(input int code);
    case (code)
      0: return 120;     1: return 180;     2: return 240;
      3: return 360;     4: return 480;
      8: return 12000;   9: return 24000;   10: return 36000;
      11: return 48000;  12: return 72000;
      15: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of expected tick cycles
  always @(negedge clk) begin
    if (rstN) begin
      if (tickNoEsc && rateSel == 4'hF) escTicks++;
      if (tickOut) begin
        seen++;
        if (expQ.size() == 0) begin
          check(1'b0, {curTag, " unexpected tick"}, cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, {curTag, " tick cycle"}, cyc, e);
        end
        if (rateSel != 4'hF)
          check(!prevTick, "R7 tick wider than one cycle", int'(prevTick), 0);
      end
      prevTick = tickOut;
    end
  end

  // driver: call at a falling edge with runEn low
  task automatic runCode(input int code, input int k, input int h, input string tag);
    int n;
    n = refRatio(code);
    curTag = tag;
    seen = 0;
    rateSel = code[3:0];
    runEn = 1'b1;
    for (int i = 1; i <= k; i++) expQ.push_back(cyc + i * n);
    repeat (k * n + h) @(negedge clk);
    runEn = 1'b0;
    repeat (3) @(negedge clk);
    check(seen == k, {tag, " tick count"}, seen, k);
    check(expQ.size() == 0, {tag, " missed ticks"}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    check(tickOut == 1'b0, "R1 tick after reset", int'(tickOut), 0);

    // R2: low band, gate dropped exactly on the last tick (R8 immediacy)
    runCode(0, 2, 0, "R2");
    runCode(1, 2, 7, "R2");
    runCode(2, 2, 3, "R2");
    runCode(3, 2, 100, "R2");
    runCode(4, 2, 1, "R2");

    // R4: reserved codes stay silent
    runCode(5, 0, 300, "R4");
    runCode(6, 0, 300, "R4");
    runCode(7, 0, 300, "R4");
    runCode(13, 0, 300, "R4");
    runCode(14, 0, 300, "R4");

    // R5 on uut, R6 on the build without escape
    escTicks = 0;
    runCode(15, 20, 0, "R5");
    check(escTicks == 0, "R6 escape-less build ticked", escTicks, 0);

    // R8: partial interval then gate off; restart needs full interval
    curTag = "R8";
    seen = 0;
    rateSel = 4'd2;
    runEn = 1'b1;
    repeat (100) @(negedge clk);
    runEn = 1'b0;
    repeat (5) @(negedge clk);
    check(seen == 0, "R8 tick during partial interval", seen, 0);
    runCode(2, 2, 5, "R8");

    // R9: code change while running restarts the interval
    curTag = "R9";
    seen = 0;
    rateSel = 4'd0;
    runEn = 1'b1;
    repeat (50) @(negedge clk);
    rateSel = 4'd1;
    expQ.push_back(cyc + 180);
    expQ.push_back(cyc + 360);
    repeat (360 + 90) @(negedge clk);
    runEn = 1'b0;
    repeat (3) @(negedge clk);
    check(seen == 2, "R9 tick count", seen, 2);
    check(expQ.size() == 0, "R9 missed ticks", expQ.size(), 0);
    expQ.delete();

    // R3: smallest and largest high-band ratios
    runCode(8, 1, 3, "R3");
    runCode(12, 1, 3, "R3");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule